// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block connects a stereo sample stream to a three-wire serial audio link. The link is driven from outside: an external bit clock and an external frame clock. The block is a slave to both. It runs on a fast system clock that oversamples those two clocks. It finds their edges, shifts 20-bit left and right samples out on a serial data pin, and collects left and right samples from a serial data input pin.

The receive and transmit directions each have their own framing choice:

| Direction | Available framings |
|---|---|
| Receive | I2S, left justified, right justified |
| Transmit | I2S, left justified |

A single input picks which bit clock edge captures data. Data is always launched on the opposite edge. With every mode input tied to zero, the port runs I2S in both directions and captures on the rising edge.

On the parallel side, the port takes a stereo pair of transmit samples when each frame starts. It signals that moment with a strobe. It delivers each received stereo pair together with a single-cycle valid strobe.

Top module: `serial_audio_port`

## Requirements
- R1: During and right after reset, `sd_out`, `tx_take`, `rx_valid`, `rx_left` and `rx_right` are all zero.
- R2: With `cap_fall` = 0, data is captured on the rising edge of `sck_in` and launched on the falling edge. With `cap_fall` = 1 the two edges swap. `sd_out` changes only in the system clock cycle that follows a launch edge.
- R3: With `tx_lj` = 0 (I2S), the left word goes out while `fs_in` is low and the right word while it is high. The MSB goes out on the second bit of the half frame, and all 20 bits follow MSB first.
- R4: With `tx_lj` = 1 (left justified), the left word goes out while `fs_in` is high. Its MSB goes out on the first bit of the half frame, followed by the other 19 bits, MSB first.
- R5: Every transmit bit position beyond the 20 data bits of a half frame carries 0.
- R6: With `rx_mode` = 00 or 11 (I2S), the receiver takes the 20 bits that start on the second bit of a half frame as a word, MSB first. Words received while `fs_in` is low are left.
- R7: With `rx_mode` = 01 (left justified), the receiver takes the first 20 bits of a half frame as a word, MSB first. Words received while `fs_in` is high are left.
- R8: With `rx_mode` = 10 (right justified), the receiver takes the last 20 bits before the frame clock transition as a word, MSB first. Words received while `fs_in` is high are left.
- R9: Received bits outside the 20-bit window of the chosen receive format have no effect on the delivered words.
- R10: `rx_valid` pulses high for exactly one cycle. The pulse comes in the cycle after the capture edge at which the transition that ends a right half frame is seen, and only if the left half of the same frame was received. `rx_left` and `rx_right` change only together with that pulse. A partial half frame seen before the first frame clock transition after reset is discarded.
- R11: At the launch edge that starts a left half frame, `tx_left` and `tx_right` are both sampled, and `tx_take` pulses for one cycle. The sampled right word is used for the following right half.
- R12: Half frames of exactly 20 bit clocks work in every format. In I2S, the LSB of a word then falls on the first bit of the next half frame, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_fall | input | 1 | 0: capture on rising bit clock edge; 1: capture on falling edge |
| tx_lj | input | 1 | Transmit framing: 0 I2S, 1 left justified |
| rx_mode | input | 2 | Receive framing: 00/11 I2S, 01 left justified, 10 right justified |
| sck_in | input | 1 | External bit clock |
| fs_in | input | 1 | External frame clock |
| sd_in | input | 1 | Serial data input |
| sd_out | output | 1 | Serial data output |
| tx_left | input | W | Left sample to transmit |
| tx_right | input | W | Right sample to transmit |
| tx_take | output | 1 | One-cycle strobe when the transmit pair is sampled |
| rx_left | output | W | Last received left sample |
| rx_right | output | W | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe when a new received pair is presented |

## Verification
Several duties collide on the single edge where the frame clock changes. On receive, that capture edge closes the word just finished and opens the next one. On transmit, the matching launch edge ends one word and starts the next. The sharpest case is a half frame of exactly 20 bit clocks. In I2S, the LSB of the finished word and the detected boundary then share one bit time. In left justified mode, the new MSB arrives on the same edge that latches the old word. The bench provokes this with runs of 20-bit-clock half frames in both framings and on both capture edges. It then checks every received pair and every transmitted bit against words it built itself, so a bit that slips by one position at the boundary shows up as a wrong LSB or MSB.

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_fall,
  input  logic         tx_lj,
  input  logic [1:0]   rx_mode,
  input  logic         sck_in,
  input  logic         fs_in,
  input  logic         sd_in,
  output logic         sd_out,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         tx_take,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic sck_q;
  always_ff @(posedge clk) sck_q <= sck_in;

  wire sck_rise = sck_in & ~sck_q;
  wire sck_fall = ~sck_in & sck_q;
  wire cap_ev   = cap_fall ? sck_fall : sck_rise;
  wire lau_ev   = cap_fall ? sck_rise : sck_fall;

  // receive side
  logic          rx_run, rx_sync, rx_fs, have_l;
  logic [W-1:0]  rsh, lhold;
  logic [CW-1:0] rcnt;

  wire rx_lj   = (rx_mode == 2'b01);
  wire rx_rj   = (rx_mode == 2'b10);
  wire rx_i2s  = ~rx_lj & ~rx_rj;
  wire rx_edge = rx_run && (fs_in != rx_fs);
  wire [W-1:0] rsh_in = {rsh[W-2:0], sd_in};
  wire [W-1:0] word   = (rx_i2s && rcnt < FULL) ? rsh_in : rsh;
  wire ended_left     = rx_i2s ? ~rx_fs : rx_fs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_run   <= 1'b0;
      rx_sync  <= 1'b0;
      rx_fs    <= 1'b0;
      have_l   <= 1'b0;
      rsh      <= '0;
      lhold    <= '0;
      rcnt     <= FULL;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cap_ev) begin
        rx_run <= 1'b1;
        rx_fs  <= fs_in;
        if (rx_edge) begin
          rx_sync <= 1'b1;
          if (rx_sync) begin
            if (ended_left) begin
              lhold  <= word;
              have_l <= 1'b1;
            end else if (have_l) begin
              rx_left  <= lhold;
              rx_right <= word;
              rx_valid <= 1'b1;
              have_l   <= 1'b0;
            end
          end
          if (rx_i2s) begin
            rcnt <= '0;
          end else begin
            rsh  <= rsh_in;
            rcnt <= CW'(1);
          end
        end else if (rx_rj || rcnt < FULL) begin
          rsh <= rsh_in;
          if (rcnt < FULL) rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  // transmit side
  logic          tx_run, tx_fs;
  logic [W-1:0]  tsh, rhold;
  logic [CW-1:0] tcnt;

  wire tx_new       = ~tx_run || (fs_in != tx_fs);
  wire tx_left_half = tx_lj ? fs_in : ~fs_in;
  wire [W-1:0] nxt_word = tx_left_half ? tx_left : rhold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_run  <= 1'b0;
      tx_fs   <= 1'b0;
      tsh     <= '0;
      rhold   <= '0;
      tcnt    <= FULL;
      sd_out  <= 1'b0;
      tx_take <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      if (lau_ev) begin
        tx_run <= 1'b1;
        tx_fs  <= fs_in;
        if (tx_new) begin
          if (tx_left_half) begin
            rhold   <= tx_right;
            tx_take <= 1'b1;
          end
          if (tx_lj) begin
            sd_out <= nxt_word[W-1];
            tsh    <= {nxt_word[W-2:0], 1'b0};
            tcnt   <= CW'(1);
          end else begin
            sd_out <= (tcnt < FULL) & tsh[W-1];
            tsh    <= nxt_word;
            tcnt   <= '0;
          end
        end else if (tcnt < FULL) begin
          sd_out <= tsh[W-1];
          tsh    <= {tsh[W-2:0], 1'b0};
          tcnt   <= tcnt + 1'b1;
        end else begin
          sd_out <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_port_chk.sv
module serial_audio_port_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_fall,
  input logic         sck_in,
  input logic         sd_out,
  input logic         tx_take,
  input logic         rx_valid,
  input logic [W-1:0] rx_left,
  input logic [W-1:0] rx_right
);
  logic sck_d;
  always_ff @(posedge clk) sck_d <= sck_in;

  wire launch  = cap_fall ? (sck_in & ~sck_d) : (~sck_in & sck_d);
  wire capture = cap_fall ? (~sck_in & sck_d) : (sck_in & ~sck_d);

  // R2
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sd_out));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

  // R10
  valid_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(capture));

  // R11
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);

  // R11
  take_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> $past(launch));
endmodule

bind serial_audio_port serial_audio_port_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_fall(cap_fall), .sck_in(sck_in),
  .sd_out(sd_out), .tx_take(tx_take), .rx_valid(rx_valid),
  .rx_left(rx_left), .rx_right(rx_right)
);

// File: tb/serial_audio_port_tb_top.sv
module serial_audio_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 20;
  localparam int HP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_fall = 1'b0, tx_lj = 1'b0;
  logic [1:0] rx_mode = 2'b00;
  logic sck_in = 1'b1, fs_in = 1'b0, sd_in = 1'b0;
  logic sd_out, tx_take, rx_valid;
  logic [W-1:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

  int n_chk = 0, n_fail = 0, n_take = 0, n_valid = 0;
  string rx_tag = "";
  logic [2*W-1:0] exp_q[$];
  logic [2*W-1:0] exp_pair;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_fall(cap_fall), .tx_lj(tx_lj),
    .rx_mode(rx_mode), .sck_in(sck_in), .fs_in(fs_in), .sd_in(sd_in),
    .sd_out(sd_out), .tx_left(tx_left), .tx_right(tx_right),
    .tx_take(tx_take), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_take) n_take++;
      if (rx_valid) begin
        n_valid++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected pair", rx_left, '0);
        end else begin
          exp_pair = exp_q.pop_front();
          check(rx_left == exp_pair[2*W-1:W], {rx_tag, " left"}, rx_left, exp_pair[2*W-1:W]);
          check(rx_right == exp_pair[W-1:0], {rx_tag, " right"}, rx_right, exp_pair[W-1:0]);
        end
      end
    end
  end

  function automatic logic rx_bit(input logic [1:0] m, input int k, input int n,
                                  input logic [W-1:0] w, input logic [W-1:0] p);
    if (m == 2'b01) return (k < W) ? w[W-1-k] : 1'b1;
    if (m == 2'b10) return (k >= n - W) ? w[n-1-k] : 1'b1;
    if (k == 0) return (n == W) ? p[0] : 1'b1;
    return (k <= W) ? w[W-k] : 1'b1;
  endfunction

  function automatic logic tx_bit(input logic lj, input int k, input int n,
                                  input logic [W-1:0] w, input logic [W-1:0] p);
    if (lj) return (k < W) ? w[W-1-k] : 1'b0;
    if (k == 0) return (n == W) ? p[0] : 1'b0;
    return (k <= W) ? w[W-k] : 1'b0;
  endfunction

  task automatic send_bit(input logic fs, input logic d, input bit chk,
                          input logic exp, input string tag);
    @(negedge clk);
    sck_in = cap_fall;
    fs_in  = fs;
    sd_in  = d;
    repeat (HP) @(negedge clk);
    if (chk) check(sd_out == exp, tag, W'(sd_out), W'(exp));
    sck_in = ~cap_fall;
    repeat (HP) @(negedge clk);
  endtask

  task automatic run_seg(input logic [1:0] rm, input logic tl, input logic ef,
                         input int n, input int nf);
    logic [W-1:0] l_w, r_w, tl_w, tr_w, w, tw, prev_rx, prev_tx;
    logic lfs, fsv;
    string ttag;
    rst_n = 1'b0;
    rx_mode = rm; tx_lj = tl; cap_fall = ef;
    sck_in = ~ef; fs_in = 1'b0; sd_in = 1'b0;
    exp_q.delete();
    lfs = (rm == 2'b01 || rm == 2'b10);
    rx_tag = (rm == 2'b01) ? "R7 R9 R2" : (rm == 2'b10) ? "R8 R9 R2" : "R6 R9 R2";
    if (n == W) rx_tag = {rx_tag, " R12"};
    tl_w = W'($urandom); tr_w = W'($urandom);
    tx_left = tl_w; tx_right = tr_w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    n_take = 0; n_valid = 0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5; k++) send_bit(lfs, 1'b1, 1'b0, 1'b0, "");
    for (int k = 0; k < n; k++) send_bit(~lfs, rx_bit(rm, k, n, '0, '1), 1'b0, 1'b0, "");
    prev_rx = '0;
    prev_tx = tr_w;
    for (int f = 0; f < nf; f++) begin
      if (f > 0) begin
        tl_w = W'($urandom); tr_w = W'($urandom);
        tx_left = tl_w; tx_right = tr_w;
      end
      l_w = W'($urandom); r_w = W'($urandom);
      exp_q.push_back({l_w, r_w});
      for (int h = 0; h < 2; h++) begin
        w   = h ? r_w : l_w;
        tw  = h ? tr_w : tl_w;
        fsv = h ? ~lfs : lfs;
        for (int k = 0; k < n; k++) begin
          if (!tl && k == 0 && n == W) ttag = "R12 R3 R11 R2";
          else if ((tl && k >= W) || (!tl && (k == 0 || k > W))) ttag = "R5 R2";
          else ttag = tl ? "R4 R11 R2" : "R3 R11 R2";
          send_bit(fsv, rx_bit(rm, k, n, w, prev_rx), 1'b1,
                   tx_bit(tl, k, n, tw, prev_tx), ttag);
        end
        prev_rx = w;
        prev_tx = tw;
      end
    end
    for (int k = 0; k < n; k++)
      send_bit(lfs, rx_bit(rm, k, n, '0, prev_rx), (k == 0 && !tl),
               tx_bit(tl, 0, n, '0, prev_tx), "R12 R3 last spill");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 pairs outstanding", W'(exp_q.size()), '0);
    check(n_valid == nf, "R10 valid count", W'(n_valid), W'(nf));
    check(n_take == nf + 2, "R11 take count", W'(n_take), W'(nf + 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sd_out == 1'b0 && tx_take == 1'b0 && rx_valid == 1'b0, "R1 flags in reset",
          W'({sd_out, tx_take, rx_valid}), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_left == '0, "R1 rx_left", rx_left, '0);
    check(rx_right == '0, "R1 rx_right", rx_right, '0);
    check(sd_out == 1'b0 && tx_take == 1'b0 && rx_valid == 1'b0, "R1 flags after reset",
          W'({sd_out, tx_take, rx_valid}), '0);
    run_seg(2'b00, 1'b0, 1'b0, 24, 3);
    run_seg(2'b01, 1'b1, 1'b1, 22, 3);
    run_seg(2'b10, 1'b1, 1'b0, 25, 3);
    run_seg(2'b11, 1'b0, 1'b1, 20, 3);
    run_seg(2'b10, 1'b1, 1'b1, 20, 3);
    run_seg(2'b01, 1'b1, 1'b0, 20, 2);
    run_seg(2'b00, 1'b0, 1'b0, 32, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule